// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the byte-level engine of an I2C master. Software loads a 32-bit control word that picks the options for one bus command: whether a START comes first, whether the command transmits or receives, how many bytes move, whether the last received byte is answered with NAK, and whether the command ends with a STOP or leaves SCL held low. Software then writes the same word again with the run bit set, and the command starts. Bus traffic is handed one operation at a time (START, write byte, read byte, STOP) to a separate bit-timing layer through a valid/done handshake.

Payload passes through a 32-bit data word holding four bus bytes. The lowest byte travels first. A data-request flag tells software that the engine needs a word to transmit or has a received word to offer. Software clears the flag through its own strobe after each data access. A typical read is two commands. The first is an address phase: START, transmit, one byte, clock retained. The second is a receive command that finishes with NAK-on-last and STOP. If the slave does not acknowledge a transmitted byte, the engine raises a no-ack flag and stays halted until it is released.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A control write with bit 31 set returns the engine to idle within one clock from any state. After that edge busy, dreq, cmplt, no_ack and scl_hold are all 0 and no bus operation is requested.
- R2: A command starts only from idle, on a control write that has bit 29 (run) and bit 17 (master) set. A control write without run, or with run but without master, leaves busy at 0 and requests no bus operation.
- R3: Bus operations run in this order: START first if bit 19 is set, then the byte operations, then STOP if bit 20 is set. A byte count of 0 issues no byte operation. Code values on bop_code: 0 START, 1 write byte, 2 read byte, 3 STOP.
- R4: With bit 16 set, the engine transmits exactly the count in bits 15:0, and the address byte is one of those bytes. Each data word goes out starting with bits 7:0, followed by bits 15:8, 23:16 and 31:24.
- R5: In transmit mode, dreq rises whenever a new data word is needed: before the first byte and after every fourth byte. The engine issues no byte operation until data_we delivers the word. dreq stays high until a dreq_clr pulse.
- R6: In receive mode, bytes fill the data word from bits 7:0 upward. The word is offered on data_rdata with dreq high once it holds four bytes or the count is exhausted. Unfilled upper bytes read as 0. The engine waits for data_re before it continues.
- R7: With bit 25 set, the final read byte of the command carries bop_nak=1. Every other read byte, and every read byte when bit 25 is clear, carries bop_nak=0.
- R8: A transmitted byte answered with bop_ackn=1 sets no_ack. The engine then halts: busy stays 1, no STOP is issued and cmplt stays 0. A nak_clr pulse returns it to idle and clears no_ack.
- R9: cmplt rises when a command finishes, which is after STOP if one was requested. It is cleared when the next command starts.
- R10: scl_hold goes to 1 when a command with bit 21 set finishes. It is cleared when the next command starts.
- R11: A requested bus operation holds bop_valid and bop_code steady until bop_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word |
| nak_clr | input | 1 | Release from the no-ack halt |
| data_we | input | 1 | Transmit data word write strobe |
| data_wdata | input | 32 | Transmit data word |
| data_re | input | 1 | Receive data word read strobe |
| data_rdata | output | 32 | Receive data word |
| dreq_clr | input | 1 | Clears the data-request flag |
| dreq | output | 1 | Data-request flag |
| cmplt | output | 1 | Command complete flag |
| no_ack | output | 1 | Slave did not acknowledge |
| busy | output | 1 | Engine not idle |
| scl_hold | output | 1 | SCL held low after command |
| bop_valid | output | 1 | Bus operation requested |
| bop_code | output | 2 | Bus operation code |
| bop_byte | output | 8 | Byte to transmit |
| bop_nak | output | 1 | Answer this read byte with NAK |
| bop_done | input | 1 | Bit layer finished the operation |
| bop_rxbyte | input | 8 | Byte received by the bit layer |
| bop_ackn | input | 1 | Slave answered NAK to written byte |

## Verification
The bench targets transmit counts that end partway through a data word, such as six bytes including the address. A design that miscounts the address byte or lane order would send a byte too few or in the wrong sequence. On the receive side, a short final word must be offered early with zeroed upper bytes, and only the very last byte may carry NAK. A design that offers only full words would hang, and one that tests the count off by one would NAK the wrong byte. A slave NAK in mid-transmit must freeze the engine without a STOP, and a soft reset is issued while a data request is pending. A design that drifts on to STOP or keeps a stale flag fails these checks.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    // control word bit positions
    localparam int CW_SRST   = 31;
    localparam int CW_RUN    = 29;
    localparam int CW_NAKL   = 25;
    localparam int CW_RETAIN = 21;
    localparam int CW_STOP   = 20;
    localparam int CW_START  = 19;
    localparam int CW_MASTER = 17;
    localparam int CW_TX     = 16;

    typedef enum logic [1:0] {
        BOP_START = 2'd0,
        BOP_WRITE = 2'd1,
        BOP_READ  = 2'd2,
        BOP_STOP  = 2'd3
    } bop_e;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_NEED, S_XFER, S_OFFER, S_STOP, S_FIN, S_HALT
    } seq_state_e;

endpackage

// File: rtl/i2c_seq_lane.sv
module i2c_seq_lane #(
    parameter int DATA_W = 32,
    localparam int NB = DATA_W / 8,
    localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              put,
    input  logic [LW-1:0]     lane,
    input  logic [7:0]        put_byte,
    output logic [DATA_W-1:0] word,
    output logic [7:0]        lane_byte
);

    logic [7:0] byte_d [NB];
    logic [7:0] byte_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign byte_d[g] = clr  ? 8'h00 :
                           load ? load_word[g*8 +: 8] :
                           (put && lane == LW'(g)) ? put_byte : byte_q[g];
        assign word[g*8 +: 8] = byte_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) byte_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < NB; i++) byte_q[i] <= byte_d[i];
        end
    end

    assign lane_byte = byte_q[lane];

    // the sequencer never loads a word and stores a received byte together
    p_no_load_put_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && put));

endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
    import i2c_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    localparam int NB = DATA_W / 8,
    localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    input  logic              nak_clr,
    input  logic              data_we,
    input  logic              data_re,
    input  logic              dreq_clr,
    input  logic              bop_done,
    input  logic              bop_ackn,
    output logic              busy,
    output logic              dreq,
    output logic              cmplt,
    output logic              no_ack,
    output logic              scl_hold,
    output logic              bop_valid,
    output logic [1:0]        bop_code,
    output logic              bop_nak,
    output logic              lane_clr,
    output logic              lane_load,
    output logic              lane_put,
    output logic [LW-1:0]     lane_idx
);

    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [LW-1:0]    LANE_LAST = LW'(NB - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [LW-1:0]    lane;
        logic             tx;
        logic             o_start;
        logic             o_stop;
        logic             o_retain;
        logic             o_nakl;
        logic             dreq;
        logic             cmplt;
        logic             noack;
        logic             hold;
    } seq_t;

    seq_t q, d;

    logic srst, go;
    logic unused_bits;
    assign unused_bits = ^{ctrl_wdata[30], ctrl_wdata[28:26], ctrl_wdata[24:22],
                           ctrl_wdata[18], ctrl_wdata[15:CNT_W-1]};

    assign srst = ctrl_we && ctrl_wdata[CW_SRST];
    assign go   = ctrl_we && ctrl_wdata[CW_RUN] && ctrl_wdata[CW_MASTER]
                  && !ctrl_wdata[CW_SRST];

    function automatic seq_state_e body_entry(logic [CNT_W-1:0] c, logic tx, logic stp);
        if (c == '0)  return stp ? S_STOP : S_FIN;
        else if (tx)  return S_NEED;
        else          return S_XFER;
    endfunction

    always_comb begin
        d         = q;
        lane_clr  = 1'b0;
        lane_load = 1'b0;
        lane_put  = 1'b0;
        if (dreq_clr) d.dreq = 1'b0;
        case (q.state)
            S_IDLE: if (go) begin
                d.cnt      = ctrl_wdata[CNT_W-1:0];
                d.lane     = '0;
                d.tx       = ctrl_wdata[CW_TX];
                d.o_start  = ctrl_wdata[CW_START];
                d.o_stop   = ctrl_wdata[CW_STOP];
                d.o_retain = ctrl_wdata[CW_RETAIN];
                d.o_nakl   = ctrl_wdata[CW_NAKL];
                d.cmplt    = 1'b0;
                d.hold     = 1'b0;
                lane_clr   = 1'b1;
                d.state    = ctrl_wdata[CW_START] ? S_START :
                             body_entry(ctrl_wdata[CNT_W-1:0], ctrl_wdata[CW_TX],
                                        ctrl_wdata[CW_STOP]);
            end
            S_START: if (bop_done) d.state = body_entry(q.cnt, q.tx, q.o_stop);
            S_NEED: if (data_we) begin
                lane_load = 1'b1;
                d.state   = S_XFER;
            end
            S_XFER: if (bop_done) begin
                if (q.tx && bop_ackn) begin
                    d.noack = 1'b1;
                    d.state = S_HALT;
                end else begin
                    lane_put = !q.tx;
                    d.cnt    = q.cnt - 1'b1;
                    d.lane   = q.lane + 1'b1;
                    if (!q.tx && (q.cnt == CNT_ONE || q.lane == LANE_LAST))
                        d.state = S_OFFER;
                    else if (q.cnt == CNT_ONE)
                        d.state = q.o_stop ? S_STOP : S_FIN;
                    else if (q.tx && q.lane == LANE_LAST)
                        d.state = S_NEED;
                    else
                        d.state = S_XFER;
                end
            end
            S_OFFER: if (data_re) begin
                lane_clr = 1'b1;
                d.state  = (q.cnt == '0) ? (q.o_stop ? S_STOP : S_FIN) : S_XFER;
            end
            S_STOP: if (bop_done) d.state = S_FIN;
            S_FIN: begin
                d.cmplt = 1'b1;
                d.hold  = q.o_retain;
                d.state = S_IDLE;
            end
            S_HALT: if (nak_clr) begin
                d.noack = 1'b0;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
        if ((d.state == S_NEED && q.state != S_NEED) ||
            (d.state == S_OFFER && q.state != S_OFFER))
            d.dreq = 1'b1;
        if (srst) begin
            d        = '0;
            d.state  = S_IDLE;
            lane_clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bop_valid = (q.state == S_START) || (q.state == S_XFER) || (q.state == S_STOP);
        case (q.state)
            S_START: bop_code = BOP_START;
            S_STOP:  bop_code = BOP_STOP;
            default: bop_code = q.tx ? BOP_WRITE : BOP_READ;
        endcase
    end

    assign bop_nak  = (q.state == S_XFER) && !q.tx && q.o_nakl && (q.cnt == CNT_ONE);
    assign busy     = (q.state != S_IDLE);
    assign dreq     = q.dreq;
    assign cmplt    = q.cmplt;
    assign no_ack   = q.noack;
    assign scl_hold = q.hold;
    assign lane_idx = q.lane;

    p_srst_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && !dreq && !cmplt && !no_ack && !scl_hold && !bop_valid));

    p_op_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bop_valid && !bop_done && !srst) |=> (bop_valid && $stable(bop_code)));

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ack && !nak_clr && !srst) |=> (no_ack && busy && !bop_valid && !cmplt));

    p_cnt_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_XFER) |-> (q.cnt != '0));

    p_cmplt_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmplt) |-> (!busy && !no_ack));

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    input  logic              nak_clr,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              data_re,
    output logic [DATA_W-1:0] data_rdata,
    input  logic              dreq_clr,
    output logic              dreq,
    output logic              cmplt,
    output logic              no_ack,
    output logic              busy,
    output logic              scl_hold,
    output logic              bop_valid,
    output logic [1:0]        bop_code,
    output logic [7:0]        bop_byte,
    output logic              bop_nak,
    input  logic              bop_done,
    input  logic [7:0]        bop_rxbyte,
    input  logic              bop_ackn
);

    localparam int NB = DATA_W / 8;
    localparam int LW = (NB > 1) ? $clog2(NB) : 1;

    logic          lane_clr, lane_load, lane_put;
    logic [LW-1:0] lane_idx;

    i2c_seq_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .nak_clr    (nak_clr),
        .data_we    (data_we),
        .data_re    (data_re),
        .dreq_clr   (dreq_clr),
        .bop_done   (bop_done),
        .bop_ackn   (bop_ackn),
        .busy       (busy),
        .dreq       (dreq),
        .cmplt      (cmplt),
        .no_ack     (no_ack),
        .scl_hold   (scl_hold),
        .bop_valid  (bop_valid),
        .bop_code   (bop_code),
        .bop_nak    (bop_nak),
        .lane_clr   (lane_clr),
        .lane_load  (lane_load),
        .lane_put   (lane_put),
        .lane_idx   (lane_idx)
    );

    i2c_seq_lane #(.DATA_W(DATA_W)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (lane_clr),
        .load      (lane_load),
        .load_word (data_wdata),
        .put       (lane_put),
        .lane      (lane_idx),
        .put_byte  (bop_rxbyte),
        .word      (data_rdata),
        .lane_byte (bop_byte)
    );

endmodule

// File: tb/i2c_cmd_seq_test.sv
`timescale 1ns/1ps
module i2c_cmd_seq_test;

    localparam logic [31:0] C_TX   = 32'h0003_0000; // master + transmit
    localparam logic [31:0] C_RX   = 32'h0002_0000; // master only
    localparam logic [31:0] C_STA  = 32'h0008_0000;
    localparam logic [31:0] C_STO  = 32'h0010_0000;
    localparam logic [31:0] C_RET  = 32'h0020_0000;
    localparam logic [31:0] C_NAKL = 32'h0200_0000;
    localparam logic [31:0] C_RUN  = 32'h2000_0000;
    localparam logic [31:0] C_SRST = 32'h8000_0000;

    logic clk = 0, rst_n = 0;
    logic ctrl_we = 0, nak_clr = 0, data_we = 0, data_re = 0, dreq_clr = 0;
    logic [31:0] ctrl_wdata = '0, data_wdata = '0, data_rdata;
    logic dreq, cmplt, no_ack, busy, scl_hold, bop_valid, bop_nak;
    logic [1:0] bop_code;
    logic [7:0] bop_byte;
    logic bop_done = 0, bop_ackn = 0;
    logic [7:0] bop_rxbyte = '0;

    int checks = 0, errors = 0;
    int nak_at = -1, wr_idx = 0;
    logic [7:0] rx_next = 8'h00;

    logic [1:0] q_code[$];
    logic [7:0] q_byte[$];
    logic       q_nak[$];
    string      q_tag[$];

    always #2.5 clk = ~clk;

    i2c_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .nak_clr(nak_clr), .data_we(data_we), .data_wdata(data_wdata),
        .data_re(data_re), .data_rdata(data_rdata), .dreq_clr(dreq_clr),
        .dreq(dreq), .cmplt(cmplt), .no_ack(no_ack), .busy(busy),
        .scl_hold(scl_hold), .bop_valid(bop_valid), .bop_code(bop_code),
        .bop_byte(bop_byte), .bop_nak(bop_nak), .bop_done(bop_done),
        .bop_rxbyte(bop_rxbyte), .bop_ackn(bop_ackn)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_op(input logic [1:0] c, input logic [7:0] b,
                           input logic n, input string tag);
        q_code.push_back(c); q_byte.push_back(b);
        q_nak.push_back(n);  q_tag.push_back(tag);
    endtask

    // monitor and bus model: pops the expected operation and answers it
    initial begin
        forever begin
            @(negedge clk);
            if (bop_valid) begin
                logic [1:0] c;
                c = bop_code;
                if (q_code.size() == 0) begin
                    check(0, "R3", "unexpected bus op", c, 0);
                end else begin
                    logic [1:0] ec; logic [7:0] eb; logic en; string et;
                    ec = q_code.pop_front(); eb = q_byte.pop_front();
                    en = q_nak.pop_front();  et = q_tag.pop_front();
                    check(c == ec, et, "bus op code", c, ec);
                    if (ec == 2'd1) check(bop_byte == eb, et, "tx byte", bop_byte, eb);
                    if (ec == 2'd2) check(bop_nak == en, et, "read nak", bop_nak, en);
                end
                begin
                    bit steady;
                    steady = 1;
                    repeat (2) begin
                        @(negedge clk);
                        if (!bop_valid || bop_code != c) steady = 0;
                    end
                    check(steady, "R11", "op held until done", steady, 1);
                end
                if (c == 2'd2) begin
                    bop_rxbyte = rx_next;
                    rx_next    = rx_next + 8'd1;
                end
                if (c == 2'd1) begin
                    bop_ackn = (wr_idx == nak_at);
                    wr_idx++;
                end
                bop_done = 1;
                @(negedge clk);
                bop_done = 0;
                bop_ackn = 0;
            end
        end
    end

    task automatic write_ctrl(input logic [31:0] w);
        @(negedge clk); ctrl_we = 1; ctrl_wdata = w;
        @(negedge clk); ctrl_we = 0;
    endtask

    task automatic wait_dreq(input string tag);
        int n = 0;
        while (!dreq && n < 2000) begin @(negedge clk); n++; end
        check(dreq, tag, "dreq raised", dreq, 1);
    endtask

    task automatic feed(input logic [31:0] w);
        wait_dreq("R5");
        check(!bop_valid, "R5", "no byte op while word missing", bop_valid, 0);
        data_we = 1; data_wdata = w; dreq_clr = 1;
        @(negedge clk); data_we = 0; dreq_clr = 0;
        check(!dreq, "R5", "dreq cleared", dreq, 0);
    endtask

    task automatic collect(input logic [31:0] w);
        wait_dreq("R6");
        check(data_rdata == w, "R6", "rx word", data_rdata, w);
        data_re = 1; dreq_clr = 1;
        @(negedge clk); data_re = 0; dreq_clr = 0;
    endtask

    task automatic wait_cmplt(input string tag);
        int n = 0;
        while (!cmplt && n < 4000) begin @(negedge clk); n++; end
        check(cmplt && !busy, tag, "command complete", {cmplt, busy}, 2'b10);
        check(q_code.size() == 0, "R3", "all expected ops seen", q_code.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check({busy, dreq, cmplt, no_ack, scl_hold, bop_valid} == 6'b0, "R1",
              "reset state", {busy, dreq, cmplt, no_ack, scl_hold, bop_valid}, 0);

        // R2: no run, then run without master
        write_ctrl(C_TX | C_STA | 32'd3);
        repeat (4) @(negedge clk);
        check(!busy && !bop_valid, "R2", "no run bit ignored", busy, 0);
        write_ctrl(C_RUN | C_STA | 32'h0001_0003);
        repeat (4) @(negedge clk);
        check(!busy && !bop_valid, "R2", "run without master ignored", busy, 0);

        // R4/R5: transmit six bytes (address + five), START and STOP
        push_op(2'd0, 8'h00, 0, "R3");
        push_op(2'd1, 8'hA4, 0, "R4"); push_op(2'd1, 8'h10, 0, "R4");
        push_op(2'd1, 8'h11, 0, "R4"); push_op(2'd1, 8'h12, 0, "R4");
        push_op(2'd1, 8'h13, 0, "R4"); push_op(2'd1, 8'h14, 0, "R4");
        push_op(2'd3, 8'h00, 0, "R3");
        write_ctrl(C_TX | C_STA | C_STO | 32'd6);
        write_ctrl(C_TX | C_STA | C_STO | C_RUN | 32'd6);
        feed(32'h1211_10A4);
        feed(32'h0000_1413);
        wait_cmplt("R9");
        check(!scl_hold, "R10", "no hold without retain", scl_hold, 0);

        // R10: address phase with retained clock, then read with NAK on last
        push_op(2'd0, 8'h00, 0, "R3");
        push_op(2'd1, 8'hA5, 0, "R4");
        write_ctrl(C_TX | C_STA | C_RET | 32'd1);
        write_ctrl(C_TX | C_STA | C_RET | C_RUN | 32'd1);
        feed(32'h0000_00A5);
        wait_cmplt("R9");
        check(scl_hold, "R10", "hold after retain", scl_hold, 1);

        rx_next = 8'h30;
        for (int i = 0; i < 6; i++) push_op(2'd2, 8'h00, (i == 5), "R7");
        push_op(2'd3, 8'h00, 0, "R3");
        write_ctrl(C_RX | C_NAKL | C_STO | 32'd6);
        write_ctrl(C_RX | C_NAKL | C_STO | C_RUN | 32'd6);
        check(!cmplt, "R9", "cmplt cleared on start", cmplt, 0);
        check(!scl_hold, "R10", "hold cleared on start", scl_hold, 0);
        collect(32'h3332_3130);
        collect(32'h0000_3534);
        wait_cmplt("R9");

        // R7: read without NAK-on-last, no START
        rx_next = 8'h50;
        push_op(2'd2, 8'h00, 0, "R7"); push_op(2'd2, 8'h00, 0, "R7");
        push_op(2'd3, 8'h00, 0, "R3");
        write_ctrl(C_RX | C_STO | 32'd2);
        write_ctrl(C_RX | C_STO | C_RUN | 32'd2);
        collect(32'h0000_5150);
        wait_cmplt("R6");

        // R8: slave NAKs the second transmitted byte
        nak_at = 1; wr_idx = 0;
        push_op(2'd0, 8'h00, 0, "R3");
        push_op(2'd1, 8'hA0, 0, "R8"); push_op(2'd1, 8'h11, 0, "R8");
        write_ctrl(C_TX | C_STA | C_STO | 32'd3);
        write_ctrl(C_TX | C_STA | C_STO | C_RUN | 32'd3);
        feed(32'h0022_11A0);
        repeat (20) @(negedge clk);
        check(no_ack && busy && !cmplt && !bop_valid, "R8", "halted after NAK",
              {no_ack, busy, cmplt, bop_valid}, 4'b1100);
        check(q_code.size() == 0, "R8", "no STOP after NAK", q_code.size(), 0);
        @(negedge clk); nak_clr = 1;
        @(negedge clk); nak_clr = 0;
        check(!busy && !no_ack, "R8", "released by nak_clr", {busy, no_ack}, 0);
        nak_at = -1;

        // R1: soft reset while a data request is pending
        push_op(2'd0, 8'h00, 0, "R3");
        write_ctrl(C_TX | C_STA | 32'd2);
        write_ctrl(C_TX | C_STA | C_RUN | 32'd2);
        wait_dreq("R5");
        write_ctrl(C_SRST);
        check({busy, dreq, cmplt, no_ack, scl_hold} == 5'b0, "R1", "soft reset idle",
              {busy, dreq, cmplt, no_ack, scl_hold}, 0);

        // R3: zero count with STOP only
        push_op(2'd3, 8'h00, 0, "R3");
        write_ctrl(C_TX | C_STO | 32'd0);
        write_ctrl(C_TX | C_STO | C_RUN | 32'd0);
        wait_cmplt("R3");

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule